// File: doc/BRIEF.md
# Uncorrectable Error Header Log with Pending-Record Queue

This block keeps the uncorrectable error status word of a link endpoint together with the log that describes the first error: a first-error pointer, four header dwords, four prefix dwords and a flag telling whether the prefix dwords are meaningful. The signalling logic hands it one record per detected error: a one-hot status bit, an optional header and an optional prefix. Software clears status bits with write-one-to-clear strobes.

When multiple header recording is switched on and the first error is still pending, a new record is parked in a small in-order queue instead of overwriting the log. When software clears the pending first-error bit, the oldest parked record moves into the log, and every parked record's status bit is raised again. A record that finds the queue full is dropped, and the block raises a one-cycle request for a correctable header-log-overflow error. The queue depth is a parameter (default 8). A depth of zero removes the queue and the capability.

Top module: `errhdr_log`

## Requirements
- R1: An accepted record (one that is logged, not queued) loads `fep_o` with the index of the single set bit of `rec_status`, and that bit is set in `status_o` from the next cycle on.
- R2: When a record is logged with `rec_hdr_valid` high, header dword i (input bits [32i+31:32i]) appears at `hdr_log_o` bits [32i+31:32i] with its four bytes reversed. When it is logged with `rec_hdr_valid` low, `hdr_log_o` becomes zero.
- R3: Prefix dwords are logged byte-reversed in the same dword order, and `pfx_flag_o` is set, only if the record has `rec_pfx_present` high and `pfx_supported` is high when it is logged. Otherwise `pfx_log_o` is zero and `pfx_flag_o` is low.
- R4: With `mhr_en` high and `status_o[fep_o]` set, a new record is queued. The log and `fep_o` stay unchanged, and its status bit is still set.
- R5: A record that would be queued while DEPTH records are already held is dropped. Its status bit is still set, and `hlo_req_o` is high for exactly the cycle after it.
- R6: A status write that leaves `status_o[fep_o]` clear, with `mhr_en` high and records queued, logs the oldest queued record. The new status is the written result ORed with the status bits of every record that was queued.
- R7: A status write that leaves `status_o[fep_o]` clear, with `mhr_en` low or the queue empty, applies the clear and zeroes `fep_o`, `pfx_flag_o`, `hdr_log_o` and `pfx_log_o`.
- R8: A status write that does not clear `status_o[fep_o]` while `mhr_en` is high has no effect on `status_o`.
- R9: A status write that does not clear `status_o[fep_o]` while `mhr_en` is low applies the clear and discards every queued record.
- R10: `mhr_capable_o` is high exactly when DEPTH is nonzero. With DEPTH zero, `mhr_en` is ignored.
- R11: Reset zeroes status, pointer, flag, both logs and `hlo_req_o`. Without a status write, no status bit ever falls.
- R12: When a status write and a record arrive in the same cycle, the write takes effect first and the record is judged against the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mhr_en | input | 1 | Multiple header recording enable |
| pfx_supported | input | 1 | End-to-end prefix support advertised |
| rec_valid | input | 1 | Error record strobe |
| rec_status | input | 32 | One-hot uncorrectable status bit of the record |
| rec_hdr_valid | input | 1 | Record carries a header |
| rec_hdr | input | 128 | Header dwords, dword i at bits [32i+31:32i] |
| rec_pfx_present | input | 1 | Record carries a prefix |
| rec_pfx | input | 128 | Prefix dwords, dword i at bits [32i+31:32i] |
| sts_wr | input | 1 | Software write-one-to-clear strobe for the status word |
| sts_wr_mask | input | 32 | Bits to clear |
| status_o | output | 32 | Uncorrectable status word |
| fep_o | output | 5 | First-error pointer |
| pfx_flag_o | output | 1 | Prefix log valid |
| hdr_log_o | output | 128 | Header log, byte-reversed dwords |
| pfx_log_o | output | 128 | Prefix log, byte-reversed dwords |
| hlo_req_o | output | 1 | Header-log-overflow correctable error request |
| mhr_capable_o | output | 1 | Multiple header recording capability |

## Verification
The assertions assume that every record strobe carries exactly one status bit. The bench builds each `rec_status` as a shift of a single one, so it stays inside that assumption. The properties on writes and records cover only cycles where one of the two strobes is active alone. The one same-cycle case, R12, is checked only by the bench, which issues it once on purpose. The bench sweeps all 32 status positions with rotating header, prefix and support settings. It then fills the queue to depth and one beyond, and drains it in order.

// File: rtl/errhdr_pkg.sv
package errhdr_pkg;
    localparam int STS_W = 32;
    localparam int FEP_W = $clog2(STS_W);
    localparam int DW_N  = 4;
    localparam int LOG_W = 32 * DW_N;

    // A record as handed over by the signalling logic
    typedef struct packed {
        logic [STS_W-1:0] status;
        logic             hdr_valid;
        logic             pfx_present;
        logic [LOG_W-1:0] hdr;
        logic [LOG_W-1:0] pfx;
    } err_rec_t;

    // Register image of the log
    typedef struct packed {
        logic [FEP_W-1:0] fep;
        logic             pfx_flag;
        logic [LOG_W-1:0] hdr;
        logic [LOG_W-1:0] pfx;
    } log_img_t;

    // Index of the lowest set bit (input is one-hot in use)
    function automatic logic [FEP_W-1:0] bit_index(input logic [STS_W-1:0] v);
        logic [FEP_W-1:0] idx;
        idx = '0;
        for (int i = STS_W - 1; i >= 0; i--) begin
            if (v[i]) idx = FEP_W'(i);
        end
        return idx;
    endfunction

    function automatic logic [31:0] swap_bytes(input logic [31:0] d);
        return {d[7:0], d[15:8], d[23:16], d[31:24]};
    endfunction
endpackage

// File: rtl/errhdr_capture.sv
// Converts a record into the register image of the log.
module errhdr_capture
    import errhdr_pkg::*;
(
    input  err_rec_t rec,
    input  logic     pfx_ok,
    output log_img_t img
);
    logic             keep_pfx;
    logic [LOG_W-1:0] hdr_w;
    logic [LOG_W-1:0] pfx_w;

    assign keep_pfx = rec.pfx_present & pfx_ok;

    for (genvar g = 0; g < DW_N; g++) begin : g_dword
        assign hdr_w[32*g +: 32] = rec.hdr_valid ? swap_bytes(rec.hdr[32*g +: 32]) : 32'h0;
        assign pfx_w[32*g +: 32] = keep_pfx      ? swap_bytes(rec.pfx[32*g +: 32]) : 32'h0;
    end

    assign img.fep      = bit_index(rec.status);
    assign img.pfx_flag = keep_pfx;
    assign img.hdr      = hdr_w;
    assign img.pfx      = pfx_w;
endmodule

// File: rtl/errhdr_queue.sv
// In-order queue of pending records; pop shifts every entry down one slot.
module errhdr_queue
    import errhdr_pkg::*;
#(
    parameter int DEPTH = 8
) (
    input  logic                                 clk,
    input  logic                                 rst,
    input  logic                                 push,
    input  logic                                 pop,
    input  logic                                 flush,
    input  err_rec_t                             din,
    output err_rec_t                             head,
    output logic [$clog2((DEPTH > 0 ? DEPTH : 1) + 1)-1:0] cnt,
    output logic [STS_W-1:0]                     any_sts
);
    localparam int SLOTS = (DEPTH > 0) ? DEPTH : 1;
    localparam int CNT_W = $clog2(SLOTS + 1);

    err_rec_t         slot_q [SLOTS];
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] wr_idx;
    logic [STS_W-1:0] acc [SLOTS+1];

    assign wr_idx = cnt_q - CNT_W'(pop);

    always_ff @(posedge clk) begin
        if (rst || flush) cnt_q <= '0;
        else              cnt_q <= cnt_q - CNT_W'(pop) + CNT_W'(push);
    end

    assign acc[0] = '0;
    for (genvar i = 0; i < SLOTS; i++) begin : g_slot
        err_rec_t next_up;
        if (i == SLOTS - 1) begin : g_last
            assign next_up = slot_q[i];
        end else begin : g_mid
            assign next_up = slot_q[i+1];
        end

        always_ff @(posedge clk) begin
            if (rst)                                 slot_q[i] <= '0;
            else if (push && wr_idx == CNT_W'(i))    slot_q[i] <= din;
            else if (pop)                            slot_q[i] <= next_up;
        end

        assign acc[i+1] = acc[i] | ((CNT_W'(i) < cnt_q) ? slot_q[i].status : '0);
    end

    assign head    = slot_q[0];
    assign cnt     = cnt_q;
    assign any_sts = acc[SLOTS];
endmodule

// File: rtl/errhdr_log.sv
module errhdr_log
    import errhdr_pkg::*;
#(
    parameter int DEPTH = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               mhr_en,
    input  logic               pfx_supported,
    input  logic               rec_valid,
    input  logic [STS_W-1:0]   rec_status,
    input  logic               rec_hdr_valid,
    input  logic [LOG_W-1:0]   rec_hdr,
    input  logic               rec_pfx_present,
    input  logic [LOG_W-1:0]   rec_pfx,
    input  logic               sts_wr,
    input  logic [STS_W-1:0]   sts_wr_mask,
    output logic [STS_W-1:0]   status_o,
    output logic [FEP_W-1:0]   fep_o,
    output logic               pfx_flag_o,
    output logic [LOG_W-1:0]   hdr_log_o,
    output logic [LOG_W-1:0]   pfx_log_o,
    output logic               hlo_req_o,
    output logic               mhr_capable_o
);
    localparam int   SLOTS = (DEPTH > 0) ? DEPTH : 1;
    localparam int   CNT_W = $clog2(SLOTS + 1);
    localparam logic HAS_Q = (DEPTH > 0);

    logic [STS_W-1:0] sts_q, sts_n, sts_clr;
    log_img_t         img_q, img_n;
    logic             hlo_q, hlo_n;
    logic             mhr_on;

    err_rec_t         in_rec, q_head;
    log_img_t         in_img, head_img;
    logic             q_push, q_pop, q_flush;
    logic [CNT_W-1:0] q_cnt;
    logic [STS_W-1:0] q_any_sts;

    assign mhr_on  = mhr_en & HAS_Q;
    assign sts_clr = sts_q & ~sts_wr_mask;

    assign in_rec = '{status: rec_status, hdr_valid: rec_hdr_valid,
                      pfx_present: rec_pfx_present, hdr: rec_hdr, pfx: rec_pfx};

    errhdr_capture u_cap_in (
        .rec    (in_rec),
        .pfx_ok (pfx_supported),
        .img    (in_img)
    );

    errhdr_capture u_cap_head (
        .rec    (q_head),
        .pfx_ok (pfx_supported),
        .img    (head_img)
    );

    errhdr_queue #(.DEPTH(DEPTH)) u_queue (
        .clk     (clk),
        .rst     (rst),
        .push    (q_push),
        .pop     (q_pop),
        .flush   (q_flush),
        .din     (in_rec),
        .head    (q_head),
        .cnt     (q_cnt),
        .any_sts (q_any_sts)
    );

    always_comb begin
        sts_n   = sts_q;
        img_n   = img_q;
        hlo_n   = 1'b0;
        q_push  = 1'b0;
        q_pop   = 1'b0;
        q_flush = 1'b0;

        // Software write is applied first
        if (sts_wr) begin
            if (!sts_clr[img_q.fep]) begin
                if (mhr_on && q_cnt != '0) begin
                    sts_n = sts_clr | q_any_sts;
                    q_pop = 1'b1;
                    img_n = head_img;
                end else begin
                    sts_n = sts_clr;
                    img_n = '0;
                end
            end else if (mhr_on) begin
                sts_n = sts_q;
            end else begin
                sts_n   = sts_clr;
                q_flush = 1'b1;
            end
        end

        // Record judged against the post-write state
        if (rec_valid) begin
            if (mhr_on && sts_n[img_n.fep]) begin
                if ((q_cnt - CNT_W'(q_pop)) < CNT_W'(DEPTH)) q_push = 1'b1;
                else                                         hlo_n  = 1'b1;
            end else begin
                img_n = in_img;
            end
            sts_n = sts_n | rec_status;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sts_q <= '0;
            img_q <= '0;
            hlo_q <= 1'b0;
        end else begin
            sts_q <= sts_n;
            img_q <= img_n;
            hlo_q <= hlo_n;
        end
    end

    assign status_o      = sts_q;
    assign fep_o         = img_q.fep;
    assign pfx_flag_o    = img_q.pfx_flag;
    assign hdr_log_o     = img_q.hdr;
    assign pfx_log_o     = img_q.pfx;
    assign hlo_req_o     = hlo_q;
    assign mhr_capable_o = HAS_Q;
endmodule

// File: rtl/errhdr_log_checker.sv
module errhdr_log_checker
    import errhdr_pkg::*;
#(
    parameter int DEPTH = 8
) (
    input logic             clk,
    input logic             rst,
    input logic             mhr_en,
    input logic             pfx_supported,
    input logic             rec_valid,
    input logic [STS_W-1:0] rec_status,
    input logic             sts_wr,
    input logic [STS_W-1:0] sts_wr_mask,
    input logic [STS_W-1:0] status_o,
    input logic [FEP_W-1:0] fep_o,
    input logic             pfx_flag_o,
    input logic [LOG_W-1:0] hdr_log_o,
    input logic [LOG_W-1:0] pfx_log_o,
    input logic             hlo_req_o
);
    localparam logic HAS_Q = (DEPTH > 0);

    p_rec_onehot_r1: assert property (@(posedge clk) disable iff (rst)
        rec_valid |-> $countones(rec_status) == 1);

    p_fep_load_r1: assert property (@(posedge clk) disable iff (rst)
        rec_valid && !sts_wr && !(HAS_Q && mhr_en && status_o[fep_o])
        |=> ((($past(rec_status) >> fep_o) & 32'd1) == 32'd1) && status_o[fep_o]);

    p_pfx_gate_r3: assert property (@(posedge clk) disable iff (rst)
        $rose(pfx_flag_o) |-> $past(pfx_supported));

    p_queue_hold_r4: assert property (@(posedge clk) disable iff (rst)
        rec_valid && !sts_wr && HAS_Q && mhr_en && status_o[fep_o]
        |=> $stable(fep_o) && $stable(hdr_log_o) && $stable(pfx_log_o));

    p_hlo_source_r5: assert property (@(posedge clk) disable iff (rst)
        hlo_req_o |-> $past(rec_valid));

    p_clear_log_r7: assert property (@(posedge clk) disable iff (rst)
        sts_wr && !rec_valid && sts_wr_mask[fep_o] && !(HAS_Q && mhr_en)
        |=> fep_o == '0 && !pfx_flag_o && hdr_log_o == '0 && pfx_log_o == '0);

    p_undo_write_r8: assert property (@(posedge clk) disable iff (rst)
        sts_wr && !rec_valid && HAS_Q && mhr_en && status_o[fep_o] && !sts_wr_mask[fep_o]
        |=> $stable(status_o));

    p_sticky_r11: assert property (@(posedge clk) disable iff (rst)
        !sts_wr |=> ($past(status_o) & ~status_o) == '0);
endmodule

bind errhdr_log errhdr_log_checker #(.DEPTH(DEPTH)) u_chk (
    .clk           (clk),
    .rst           (rst),
    .mhr_en        (mhr_en),
    .pfx_supported (pfx_supported),
    .rec_valid     (rec_valid),
    .rec_status    (rec_status),
    .sts_wr        (sts_wr),
    .sts_wr_mask   (sts_wr_mask),
    .status_o      (status_o),
    .fep_o         (fep_o),
    .pfx_flag_o    (pfx_flag_o),
    .hdr_log_o     (hdr_log_o),
    .pfx_log_o     (pfx_log_o),
    .hlo_req_o     (hlo_req_o)
);

// File: tb/errhdr_log_bench.sv
module errhdr_log_bench;
    localparam int DEPTH = 8;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         mhr_en = 1'b0;
    logic         pfx_supported = 1'b0;
    logic         rec_valid = 1'b0;
    logic [31:0]  rec_status = '0;
    logic         rec_hdr_valid = 1'b0;
    logic [127:0] rec_hdr = '0;
    logic         rec_pfx_present = 1'b0;
    logic [127:0] rec_pfx = '0;
    logic         sts_wr = 1'b0;
    logic [31:0]  sts_wr_mask = '0;
    logic [31:0]  status_o;
    logic [4:0]   fep_o;
    logic         pfx_flag_o;
    logic [127:0] hdr_log_o;
    logic [127:0] pfx_log_o;
    logic         hlo_req_o;
    logic         mhr_capable_o;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    errhdr_log #(.DEPTH(DEPTH)) u_errhdr_log (.*);

    function automatic logic [31:0] hpat(int b, int i);
        return 32'h1357_9BDF ^ (32'(b) * 32'h0101_0101) + 32'(i) * 32'h1111_1111;
    endfunction

    function automatic logic [127:0] raw_blk(int b, bit inv);
        logic [127:0] r;
        for (int i = 0; i < 4; i++) r[32*i +: 32] = inv ? ~hpat(b, i) : hpat(b, i);
        return r;
    endfunction

    function automatic logic [127:0] log_blk(int b, bit inv);
        logic [127:0] r;
        logic [31:0] d;
        for (int i = 0; i < 4; i++) begin
            d = inv ? ~hpat(b, i) : hpat(b, i);
            r[32*i +: 32] = {d[7:0], d[15:8], d[23:16], d[31:24]};
        end
        return r;
    endfunction

    task automatic check(string req, logic [127:0] act, logic [127:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic send_rec(int b, bit hv, bit pp);
        @(negedge clk);
        rec_valid = 1'b1;
        rec_status = 32'd1 << b;
        rec_hdr_valid = hv;
        rec_hdr = raw_blk(b, 1'b0);
        rec_pfx_present = pp;
        rec_pfx = raw_blk(b, 1'b1);
        @(negedge clk);
        rec_valid = 1'b0;
    endtask

    task automatic sw_clear(logic [31:0] m);
        @(negedge clk);
        sts_wr = 1'b1;
        sts_wr_mask = m;
        @(negedge clk);
        sts_wr = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] exp_sts;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R11 reset state, R10 capability
        check("R11 status", 128'(status_o), 0);
        check("R11 fep", 128'(fep_o), 0);
        check("R11 logs", hdr_log_o | pfx_log_o, 0);
        check("R11 flags", 128'({pfx_flag_o, hlo_req_o}), 0);
        check("R10 capable", 128'(mhr_capable_o), 1);

        // R1/R2/R3/R7 sweep over every status position, recording off
        for (int b = 0; b < 32; b++) begin
            bit hv, pp, ps;
            hv = (b % 2) == 0;
            pp = (b % 3) != 1;
            ps = (b % 4) < 2;
            pfx_supported = ps;
            send_rec(b, hv, pp);
            check("R1 fep", 128'(fep_o), 128'(b));
            check("R1 status", 128'(status_o), 128'(32'd1 << b));
            check("R2 header", hdr_log_o, hv ? log_blk(b, 1'b0) : 128'h0);
            check("R3 prefix", pfx_log_o, (pp && ps) ? log_blk(b, 1'b1) : 128'h0);
            check("R3 flag", 128'(pfx_flag_o), 128'(pp && ps));
            sw_clear(32'hFFFF_FFFF);
            check("R7 status", 128'(status_o), 0);
            check("R7 log", {hdr_log_o | pfx_log_o} | 128'({fep_o, pfx_flag_o}), 0);
        end

        // Queueing, R4
        pfx_supported = 1'b1;
        mhr_en = 1'b1;
        send_rec(3, 1'b1, 1'b1);
        exp_sts = 32'd1 << 3;
        for (int b = 10; b < 10 + DEPTH; b++) begin
            send_rec(b, 1'b1, 1'b0);
            exp_sts |= 32'd1 << b;
        end
        check("R4 fep held", 128'(fep_o), 3);
        check("R4 header held", hdr_log_o, log_blk(3, 1'b0));
        check("R4 status", 128'(status_o), 128'(exp_sts));

        // R5 overflow
        send_rec(25, 1'b1, 1'b0);
        exp_sts |= 32'd1 << 25;
        check("R5 hlo pulse", 128'(hlo_req_o), 1);
        check("R5 status", 128'(status_o), 128'(exp_sts));
        check("R5 log held", 128'(fep_o), 3);
        @(negedge clk);
        check("R5 hlo one cycle", 128'(hlo_req_o), 0);

        // R8 write that misses the first-error bit is undone
        sw_clear(32'd1 << 12);
        check("R8 status kept", 128'(status_o), 128'(exp_sts));

        // R6 drain in order
        sw_clear(32'd1 << 3);
        exp_sts &= ~(32'd1 << 3);
        check("R6 fep", 128'(fep_o), 10);
        check("R6 header", hdr_log_o, log_blk(10, 1'b0));
        check("R6 prefix off", 128'({pfx_flag_o}) | pfx_log_o, 0);
        check("R6 status", 128'(status_o), 128'(exp_sts));
        for (int b = 10; b < 10 + DEPTH - 1; b++) begin
            sw_clear(32'd1 << b);
            check("R6 next fep", 128'(fep_o), 128'(b + 1));
            check("R6 next header", hdr_log_o, log_blk(b + 1, 1'b0));
            check("R6 status kept", 128'(status_o), 128'(exp_sts & ~((32'd1 << (b + 1)) - 1)));
        end
        sw_clear(32'd1 << (10 + DEPTH - 1));
        check("R7 empty queue log", hdr_log_o | 128'(fep_o), 0);
        check("R7 empty queue status", 128'(status_o), 128'(32'd1 << 25));
        sw_clear(32'hFFFF_FFFF);

        // R9 flush when recording is off
        send_rec(1, 1'b1, 1'b0);
        send_rec(2, 1'b1, 1'b0);
        send_rec(4, 1'b1, 1'b0);
        mhr_en = 1'b0;
        sw_clear(32'd1 << 2);
        check("R9 status", 128'(status_o), 128'((32'd1 << 1) | (32'd1 << 4)));
        mhr_en = 1'b1;
        sw_clear(32'd1 << 1);
        check("R9 queue flushed", hdr_log_o | 128'(fep_o), 0);
        check("R9 status after", 128'(status_o), 128'(32'd1 << 4));
        sw_clear(32'hFFFF_FFFF);

        // R12 write and record in the same cycle
        send_rec(7, 1'b1, 1'b0);
        send_rec(8, 1'b1, 1'b0);
        @(negedge clk);
        sts_wr = 1'b1;
        sts_wr_mask = 32'd1 << 7;
        rec_valid = 1'b1;
        rec_status = 32'd1 << 9;
        rec_hdr_valid = 1'b1;
        rec_hdr = raw_blk(9, 1'b0);
        rec_pfx_present = 1'b0;
        @(negedge clk);
        sts_wr = 1'b0;
        rec_valid = 1'b0;
        check("R12 popped first", 128'(fep_o), 8);
        check("R12 status", 128'(status_o), 128'((32'd1 << 8) | (32'd1 << 9)));
        sw_clear(32'd1 << 8);
        check("R12 record queued", 128'(fep_o), 9);
        check("R12 header", hdr_log_o, log_blk(9, 1'b0));

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule